// File: doc/BRIEF.md
# Flip-Flop Synchronous FIFO

This block is a single-clock first-in first-out queue. Its storage is a small register array. A write pointer and a read pointer index the array, and each pointer carries one extra wrap bit above its address bits. An upstream producer pulses `load` with a word on `din`, and a downstream consumer pulses `extract` to take the oldest word. The oldest stored word is always visible on `dout` without waiting for a clock edge. The `full` and `empty` flags are decoded directly from the two pointers.

The word width and the depth are parameters, and the depth must be a power of two. The address width is a separate parameter equal to log2 of the depth. A further parameter selects whether the active-low reset acts synchronously or asynchronously.

When the queue is full, a load is still taken if an extract happens in the same cycle. Upstream logic that cannot see `extract` should therefore gate `load` with `full` itself.

Top module: `flop_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers return to zero, so `empty` reads 1 and `full` reads 0.
- R2: Words leave in the order they were accepted. While `empty` is 0, `dout` shows the oldest stored word combinationally, and an extract in that cycle removes it at the clock edge.
- R3: A load while `full` is 1 and `extract` is 0 is ignored. `full` stays 1, `dout` holds, and the rejected word never appears on a later read.
- R4: An extract while `empty` is 1 and `load` is 0 is ignored. `empty` stays 1 and later traffic is unaffected.
- R5: After DEPTH accepted loads with no extract, starting from empty, `full` reads 1 and `empty` reads 0. `full` is 1 exactly when DEPTH words are held.
- R6: With `full` at 1, a simultaneous load and extract both take effect. The oldest word leaves, the new word joins the tail, and `full` stays 1.
- R7: With `empty` at 1, a simultaneous load and extract performs only the write. In the next cycle `empty` is 0 and `dout` shows the loaded word.
- R8: `full` and `empty` are never 1 together.
- R9: The pointers wrap modulo twice the depth with no clearing logic. Ordering and flags stay correct across many wraps, and each pointer moves by at most one entry per cycle.
- R10: With the reset mode parameter set to asynchronous (the default), driving `rst_n` low empties the queue at once, with no clock edge. With it set to synchronous, the reset is applied on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| load | input | 1 | Write strobe for `din` |
| din | input | DW | Word to enqueue |
| extract | input | 1 | Read strobe; removes the word on `dout` |
| dout | output | DW | Oldest stored word |
| full | output | 1 | DEPTH words held |
| empty | output | 1 | No words held |

## Verification
The properties assume that `load` and `extract` are clean single-bit levels that are stable around each rising edge. They also assume that reset is held for at least one edge before traffic starts. The bench meets both assumptions by changing inputs only on the falling edge, and by raising `rst_n` only on a falling edge after at least one rising edge in reset. The asynchronous reset is asserted mid-cycle on purpose, and only while both strobes are low, so no property sees a transfer racing the reset.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;
    typedef enum logic {
        RST_SYNC  = 1'b0,
        RST_ASYNC = 1'b1
    } rst_mode_e;
endpackage

// File: rtl/sfifo_flags.sv
`timescale 1ns/1ps
// Status decode from wrap-bit pointers.
module sfifo_flags #(
    parameter int AW = 4
) (
    input  logic [AW:0] wr_ptr,
    input  logic [AW:0] rd_ptr,
    output logic        full,
    output logic        empty
);
    logic addr_same;
    logic wrap_same;

    always_comb begin
        addr_same = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
        wrap_same = (wr_ptr[AW] == rd_ptr[AW]);
        empty     = addr_same && wrap_same;
        full      = addr_same && !wrap_same;
    end
endmodule

// File: rtl/sfifo_store.sv
`timescale 1ns/1ps
// Register array with one write port and one combinational read port.
module sfifo_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/flop_fifo.sv
`timescale 1ns/1ps
module flop_fifo
    import sfifo_pkg::*;
#(
    parameter int        DW       = 8,
    parameter int        DEPTH    = 16,
    parameter int        AW       = 4,
    parameter rst_mode_e RST_MODE = RST_ASYNC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          extract,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          empty
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
    } ptr_pair_t;

    ptr_pair_t st_d, st_q;
    logic      load_ok;
    logic      take_ok;

    // Acceptance: a load while full needs a same-cycle extract.
    always_comb begin
        load_ok = load && (!full || extract);
        take_ok = extract && !empty;
        st_d    = st_q;
        if (load_ok) begin
            st_d.wr = st_q.wr + PW'(1);
        end
        if (take_ok) begin
            st_d.rd = st_q.rd + PW'(1);
        end
    end

    generate
        if (RST_MODE == RST_ASYNC) begin : g_arst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
        end else begin : g_srst
            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
        end
    endgenerate

    sfifo_flags #(.AW(AW)) u_flags (
        .wr_ptr (st_q.wr),
        .rd_ptr (st_q.rd),
        .full   (full),
        .empty  (empty)
    );

    sfifo_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (load_ok),
        .wr_addr (st_q.wr[AW-1:0]),
        .wr_data (din),
        .rd_addr (st_q.rd[AW-1:0]),
        .rd_data (dout)
    );
endmodule

// File: rtl/fifo_chk.sv
`timescale 1ns/1ps
module fifo_chk #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic          extract,
    input logic [DW-1:0] dout,
    input logic          full,
    input logic          empty,
    input logic [AW:0]   wr_ptr,
    input logic [AW:0]   rd_ptr
);
    localparam int PW = AW + 1;

    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && wr_ptr == '0 && rd_ptr == '0));

    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && load && !extract) |=> (full && $stable(wr_ptr) && $stable(dout)));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && extract && !load) |=> (empty && $stable(rd_ptr)));

    p_full_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && load && extract) |=> (full && wr_ptr != $past(wr_ptr) && rd_ptr != $past(rd_ptr)));

    p_empty_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && load) |=> (!empty && $stable(rd_ptr)));

    p_wr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr == $past(wr_ptr)) || (wr_ptr == PW'($past(wr_ptr) + 1'b1)));

    p_rd_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr == $past(rd_ptr)) || (rd_ptr == PW'($past(rd_ptr) + 1'b1)));
endmodule

bind flop_fifo fifo_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .extract (extract),
    .dout    (dout),
    .full    (full),
    .empty   (empty),
    .wr_ptr  (st_q.wr),
    .rd_ptr  (st_q.rd)
);

// File: tb/sim_flop_fifo.sv
`timescale 1ns/1ps
module sim_flop_fifo;
    localparam int DW    = 8;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic          extract = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          full;
    logic          empty;

    int    nchk = 0;
    int    nfail = 0;
    int    cnt = 0;
    bit    done = 1'b0;
    string phase = "R1";
    logic [DW-1:0] sb_q[$];
    event  ev_pop;

    always #5 clk = ~clk;

    flop_fifo #(.DW(DW), .DEPTH(DEPTH), .AW(4)) u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .din(din),
        .extract(extract), .dout(dout), .full(full), .empty(empty)
    );

    task automatic check(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %0s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: compares the word leaving against the scoreboard head.
    initial begin
        forever begin
            @(ev_pop);
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", int'(dout), 0);
            end else begin
                check(dout == sb_q[0], "R2", int'(dout), int'(sb_q[0]));
                void'(sb_q.pop_front());
            end
        end
    end

    // Driver: one cycle of stimulus, with a flag check before the edge.
    task automatic step(bit ld, bit ex, logic [DW-1:0] d);
        bit ld_ok;
        bit ex_ok;
        @(negedge clk);
        load = ld; extract = ex; din = d;
        #1;
        check(full == (cnt == DEPTH), {phase, " full"}, int'(full), int'(cnt == DEPTH));
        check(empty == (cnt == 0), {phase, " empty"}, int'(empty), int'(cnt == 0));
        check(!(full && empty), "R8", int'({full, empty}), 0);
        ld_ok = ld && (cnt < DEPTH || ex);
        ex_ok = ex && (cnt > 0);
        if (ex_ok) -> ev_pop;
        if (ld_ok) sb_q.push_back(d);
        cnt = cnt + int'(ld_ok) - int'(ex_ok);
    endtask

    initial begin
        #1;
        check(empty === 1'b1 && full === 1'b0, "R1", int'({full, empty}), 1);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        phase = "R2";
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, DW'(8'h10 + i));
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, DW'(8'h20 + i));
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, '0);

        phase = "R4";
        step(1'b0, 1'b1, '0);
        step(1'b0, 1'b1, '0);
        step(1'b0, 1'b0, '0);

        phase = "R7";
        step(1'b1, 1'b1, 8'hA7);
        step(1'b0, 1'b0, '0);
        check(dout == 8'hA7, "R7", int'(dout), 'hA7);
        step(1'b0, 1'b1, '0);

        phase = "R5";
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, DW'(8'h40 + i));
        step(1'b0, 1'b0, '0);

        phase = "R3";
        step(1'b1, 1'b0, 8'hEE);
        step(1'b1, 1'b0, 8'hEF);
        step(1'b0, 1'b0, '0);
        check(dout == 8'h40, "R3", int'(dout), 'h40);

        phase = "R6";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, DW'(8'h90 + i));
        step(1'b0, 1'b0, '0);

        phase = "R2";
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, '0);
        step(1'b0, 1'b0, '0);

        phase = "R9";
        for (int i = 0; i < 8 * DEPTH; i++) begin
            step(((i % 3) != 2), ((i % 5) < 3), DW'(i * 7));
        end
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b1, '0);

        phase = "R10";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, DW'(8'hC0 + i));
        @(negedge clk);
        load = 1'b0; extract = 1'b0;
        #2 rst_n = 1'b0;
        #1;
        check(empty == 1'b1 && full == 1'b0, "R10", int'({full, empty}), 1);
        sb_q.delete();
        cnt = 0;
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 8'h5A);
        step(1'b0, 1'b1, '0);
        step(1'b0, 1'b0, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule